// File: doc/BRIEF.md
# Overcurrent Threshold Sample-and-Hold

This block digitizes an externally programmed overcurrent threshold once per start-up and holds it for the protection logic. A start strobe launches a sample. An up-counter, advanced once per prescaled tick, drives the code of an external DAC. An external comparator reports when the DAC level has reached the voltage sensed on the threshold pin. The count at that moment is frozen and held as the threshold code.

Because the counter only counts up, a small threshold is captured after a few ticks and a large one takes close to the full ramp. A ramp that reaches full scale without a comparator trip means the pin is open or set too high. In that case the code is held at full scale and protection is reported as off.

The system asserts the start strobe only when the post-reset delay ends or a shutdown is released, and never on an overcurrent retry. Between strobes the held code stays fixed for as long as the supply-good flag stays high. The held code is also presented doubled, as the detect level for the switch-node drop.

Top module: `ocp_sh_top`

## Requirements
- R1: While reset is applied and after it is released, before any start strobe, thr_code_o, trip_code_o, dac_code_o, done_o and ocp_en_o are all zero.
- R2: When a start strobe is sampled in idle, dac_code_o begins at 0 and rises by exactly one every TICK_DIV cycles, where TICK_DIV = MAX_SAMPLE_CYCLES / 2^CODE_W. The code reached k cycles after the start edge is floor(k / TICK_DIV).
- R3: cmp_i high means the DAC level is at or above the sensed voltage. The first cycle in which cmp_i is high during a ramp causes the current dac_code_o to be captured into thr_code_o at the next edge. For a trip at code k, done_o rises k*TICK_DIV+1 cycles after the start edge.
- R4: If cmp_i stays low, the code stops at full scale (all ones). After that code has been held for TICK_DIV cycles, full scale is captured, so done_o rises 2^CODE_W*TICK_DIV cycles after the start edge.
- R5: ocp_en_o is high after a capture if and only if the captured code is below full scale. A capture at full scale, whether by trip or by timeout, leaves ocp_en_o low.
- R6: thr_code_o and ocp_en_o change only in the cycle in which done_o is high, or after supply-good drops. They keep their old values during a ramp and in idle.
- R7: A start strobe sampled while a ramp is running is ignored: the ramp and its capture time are unaffected.
- R8: One cycle after supply_ok_i is sampled low, thr_code_o, ocp_en_o, dac_code_o and done_o are zero and any ramp is aborted. While supply_ok_i is low, start strobes are ignored. A new value is held only after a later strobe.
- R9: trip_code_o, one bit wider than the code, always equals twice thr_code_o.
- R10: done_o is a one-cycle pulse. In the cycle it is high, dac_code_o is already back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-sample strobe (delay end or shutdown release) |
| cmp_i | input | 1 | Comparator: DAC level at or above sensed pin voltage |
| supply_ok_i | input | 1 | Supply-good flag; low clears the held threshold |
| dac_code_o | output | CODE_W | Ramp code driving the external DAC |
| thr_code_o | output | CODE_W | Held threshold code |
| trip_code_o | output | CODE_W+1 | Held code times two, the detect level for the switch-node drop |
| done_o | output | 1 | One-cycle pulse when a new code is captured |
| ocp_en_o | output | 1 | Overcurrent protection enabled (held code below full scale) |

## Verification
A prescaler off by one shows at the ports within the first few ticks, because dac_code_o reaches a code at the wrong cycle. It then shifts the done_o latency of every capture by a multiple of the level. A stuck or mis-sequenced control state shows within one cycle: a second done_o pulse, a non-zero dac_code_o beside done_o, a restart accepted mid-ramp, or a held code that moves without done_o. A hold register that misses the supply-good clear, or that decodes full scale wrongly, shows in thr_code_o and ocp_en_o in the cycle after the supply drop or the capture.

// File: rtl/ocp_sh_pkg.sv
package ocp_sh_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } sh_state_e;

  // cycles per ramp step; never below one
  function automatic int unsigned tick_div(input int unsigned max_cycles,
                                           input int unsigned steps);
    int unsigned d;
    d = max_cycles / steps;
    return (d < 1) ? 1 : d;
  endfunction

endpackage

// File: rtl/ocp_sh_tick.sv
module ocp_sh_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_direct
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign tick_o = run_i;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (!run_i || cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick_o = run_i && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/ocp_sh_ramp.sv
module ocp_sh_ramp #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [CODE_W-1:0] code_o,
  output logic              full_o
);

  logic [CODE_W-1:0] code_q;

  assign full_o = &code_q;
  assign code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
    end else if (clr_i) begin
      code_q <= '0;
    end else if (step_i && !full_o) begin
      code_q <= code_q + 1'b1;
    end
  end

endmodule

// File: rtl/ocp_sh_ctrl.sv
module ocp_sh_ctrl
  import ocp_sh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cmp_i,
  input  logic supply_ok_i,
  input  logic tick_i,
  input  logic full_i,
  output logic run_o,
  output logic clr_o,
  output logic cap_o
);

  sh_state_e state_q, state_d;

  always_comb begin
    cap_o   = 1'b0;
    state_d = state_q;
    if (!supply_ok_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_d = ST_RAMP;
        ST_RAMP: begin
          if (cmp_i || (tick_i && full_i)) begin
            cap_o   = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign run_o = (state_q == ST_RAMP) && supply_ok_i;
  // code returns to zero on the capture edge and whenever idle
  assign clr_o = (state_q == ST_IDLE) || !supply_ok_i || cap_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/ocp_sh_hold.sv
module ocp_sh_hold #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic              cap_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] thr_o,
  output logic [CODE_W:0]   trip_o,
  output logic              en_o,
  output logic              done_o
);

  logic [CODE_W-1:0] thr_q;
  logic              en_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (!supply_ok_i) begin
      thr_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= cap_i;
      if (cap_i) begin
        thr_q <= code_i;
        en_q  <= ~&code_i;  // full scale: open pin, protection off
      end
    end
  end

  assign thr_o  = thr_q;
  assign trip_o = {thr_q, 1'b0};
  assign en_o   = en_q;
  assign done_o = done_q;

endmodule

// File: rtl/ocp_sh_top.sv
module ocp_sh_top #(
  parameter int unsigned CODE_W            = 6,
  parameter int unsigned MAX_SAMPLE_CYCLES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmp_i,
  input  logic              supply_ok_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [CODE_W-1:0] thr_code_o,
  output logic [CODE_W:0]   trip_code_o,
  output logic              done_o,
  output logic              ocp_en_o
);

  localparam int unsigned STEPS    = 1 << CODE_W;
  localparam int unsigned TICK_DIV = ocp_sh_pkg::tick_div(MAX_SAMPLE_CYCLES, STEPS);

  logic run, clr, cap, tick, full;

  ocp_sh_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cmp_i       (cmp_i),
    .supply_ok_i (supply_ok_i),
    .tick_i      (tick),
    .full_i      (full),
    .run_o       (run),
    .clr_o       (clr),
    .cap_o       (cap)
  );

  ocp_sh_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  ocp_sh_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (tick),
    .code_o (dac_code_o),
    .full_o (full)
  );

  ocp_sh_hold #(.CODE_W(CODE_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .cap_i       (cap),
    .code_i      (dac_code_o),
    .thr_o       (thr_code_o),
    .trip_o      (trip_code_o),
    .en_o        (ocp_en_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/ocp_sh_chk.sv
module ocp_sh_chk #(
  parameter int unsigned CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              supply_ok_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic [CODE_W-1:0] thr_code_o,
  input logic              done_o,
  input logic              ocp_en_o
);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  dac_zero_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dac_code_o == '0));

  // R8
  supply_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (thr_code_o == '0 && !ocp_en_o && !done_o && dac_code_o == '0));

  // R5
  en_below_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocp_en_o |-> (thr_code_o != {CODE_W{1'b1}}));

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && $past(supply_ok_i)) |-> ($stable(thr_code_o) && $stable(ocp_en_o)));

  // R2
  ramp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_code_o != $past(dac_code_o)) |->
      (dac_code_o == CODE_W'($past(dac_code_o) + 1'b1) || dac_code_o == '0));

endmodule

bind ocp_sh_top ocp_sh_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_ok_i (supply_ok_i),
  .dac_code_o  (dac_code_o),
  .thr_code_o  (thr_code_o),
  .done_o      (done_o),
  .ocp_en_o    (ocp_en_o)
);

// File: tb/ocp_sh_top_tb.sv
module ocp_sh_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 6;
  localparam int MAX_CYC    = 256;
  localparam int STEPS      = 1 << CODE_W;
  localparam int FULL       = STEPS - 1;
  localparam int D          = MAX_CYC / STEPS;

  localparam int NV = 8;
  // sensed level (in DAC codes, >FULL = open pin), expected code, enable, latency
  localparam int V_LVL [NV] = '{0, 1, 5, 17, 31, 62, 63, 100};
  localparam int V_THR [NV] = '{0, 1, 5, 17, 31, 62, 63, 63};
  localparam int V_EN  [NV] = '{1, 1, 1, 1,  1,  1,  0,  0};
  localparam int V_LAT [NV] = '{1, 5, 21, 69, 125, 249, 253, 256};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic supply_ok = 1'b1;
  logic cmp;
  logic [CODE_W-1:0] dac_code, thr_code;
  logic [CODE_W:0]   trip_code;
  logic done, ocp_en;
  int level = 1000;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator and DAC model
  assign cmp = supply_ok && (int'(dac_code) >= level);

  ocp_sh_top #(.CODE_W(CODE_W), .MAX_SAMPLE_CYCLES(MAX_CYC)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cmp_i       (cmp),
    .supply_ok_i (supply_ok),
    .dac_code_o  (dac_code),
    .thr_code_o  (thr_code),
    .trip_code_o (trip_code),
    .done_o      (done),
    .ocp_en_o    (ocp_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_sample(input int lvl, input int exp_thr, input int exp_en,
                           input int exp_lat, input int restart_at,
                           input int probe_at, input int probe_dac, input int probe_thr);
    int n;
    bit got;
    level = lvl;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    got = 0;
    while (n < 2000 && !got) begin
      if (n == probe_at) begin
        chk(int'(dac_code) == probe_dac, "R2 ramp code", int'(dac_code), probe_dac);
        chk(int'(thr_code) == probe_thr, "R6 held during ramp", int'(thr_code), probe_thr);
      end
      if (done) got = 1;
      else begin
        start = (n == restart_at);
        @(negedge clk);
        n++;
      end
    end
    start = 1'b0;
    chk(got && n == exp_lat, "R3/R4 done latency", n, exp_lat);
    chk(int'(thr_code) == exp_thr, "R3/R4 held code", int'(thr_code), exp_thr);
    chk(int'(ocp_en) == exp_en, "R5 ocp enable", int'(ocp_en), exp_en);
    chk(int'(trip_code) == 2 * exp_thr, "R9 trip code", int'(trip_code), 2 * exp_thr);
    chk(dac_code == '0, "R10 dac zero at done", int'(dac_code), 0);
    @(negedge clk);
    chk(!done, "R10 done one cycle", int'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(thr_code == '0 && trip_code == '0 && dac_code == '0 && !done && !ocp_en,
        "R1 in reset", int'(thr_code), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(thr_code == '0 && dac_code == '0 && !done && !ocp_en,
        "R1 after reset", int'(dac_code), 0);

    // table of levels: R3 R4 R5 R9 R10
    for (int i = 0; i < NV; i++) begin
      do_sample(V_LVL[i], V_THR[i], V_EN[i], V_LAT[i], -1, -1, 0, 0);
      repeat (3) @(negedge clk);
    end

    // R6: held value unaffected in idle while the sensed level moves
    level = 3;
    repeat (40) @(negedge clk);
    chk(int'(thr_code) == 63 && !ocp_en && !done, "R6 idle hold", int'(thr_code), 63);

    // R2 ramp steps and R6 old code kept mid-ramp
    do_sample(10, 10, 1, 10 * D + 1, -1, 9, 9 / D, 63);
    do_sample(12, 12, 1, 12 * D + 1, -1, 12, 12 / D, 10);

    // R7 restart mid-ramp ignored
    do_sample(20, 20, 1, 20 * D + 1, 10, 30, 30 / D, 12);

    // R8 supply drop mid-ramp
    level = 30;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    chk(thr_code == '0 && !ocp_en && dac_code == '0 && !done,
        "R8 supply drop clears", int'(thr_code), 0);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done || dac_code != '0) n++;
    end
    chk(n == 0, "R8 start ignored while supply low", n, 0);
    supply_ok = 1'b1;
    repeat (300) @(negedge clk);
    chk(thr_code == '0 && !ocp_en && !done, "R8 no sample without strobe", int'(thr_code), 0);
    do_sample(7, 7, 1, 7 * D + 1, -1, -1, 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule